// File: doc/BRIEF.md
# Banked Internal RAM Address Unit

This unit sits between the execution stage of an 8-bit microcontroller core and its on-chip data storage. It owns a 256-byte internal RAM and drives a generic read/write port toward the special-function register file. The core hands it one request at a time: a byte read or write tagged direct or indirect, a working-register reference R0..R7, a single-bit operation on an 8-bit bit address, or a stack push or pop. The unit works out where the request lands, does the access, and returns one response.

Byte addresses below 0x80 always reach the lower RAM. The upper half of the byte address range depends on how it is reached. A direct access goes to the register port. An indirect access goes to a second RAM page that direct accesses can never see. An indirect access takes its address from R0 or R1 of the bank chosen by the two bank-select inputs. A 128-bit space overlays sixteen bytes of lower RAM. Bit addresses from 0x80 upward select bits of register bytes whose addresses are multiples of eight. Bit changes are done as a read, a modify and a write-back. The stack pointer lives inside the unit and its value is visible at a port.

The controller is a state machine with six states. In IDLE it accepts a request. PTR_FETCH reads R0/R1 of the active bank to get the pointer for an indirect access, then goes to BYTE_XFER. BYTE_XFER performs the byte read or write and returns to IDLE. BIT_READ reads the byte that holds the bit. From there it returns to IDLE for a bit test, or moves to BIT_WRITE for set, clear or complement. BIT_WRITE writes the modified byte back and returns to IDLE. STACK moves one byte, adjusts the pointer and returns to IDLE. IDLE chooses its next state from the incoming operation. An unknown operation code keeps it in IDLE.

Top module: `iram_addr_unit`

## Requirements
- R1: Byte addresses 0x00..0x7F reach the same lower RAM bytes whether the request is direct (req_ind=0) or indirect (req_ind=1). Operation codes are: 0 byte read, 1 byte write, 2 register read, 3 register write, 4 bit test, 5 bit set, 6 bit clear, 7 bit complement, 8 push, 9 pop.
- R2: A direct byte access to 0x80..0xFF goes to the register port. sfr_addr carries the byte address. A read returns sfr_rdata. A write pulses sfr_we with the data on sfr_wdata.
- R3: An indirect byte access whose pointer is 0x80..0xFF reaches a separate upper RAM page and raises neither sfr_re nor sfr_we.
- R4: A register operation with req_addr[2:0]=n under bank_sel=k (bank_sel is RS1:RS0) reaches RAM byte 8*k+n.
- R5: An indirect byte access uses, as its address, the content of R0 (req_addr[0]=0) or R1 (req_addr[0]=1) of the bank given by bank_sel.
- R6: Bit address b below 0x80 selects bit b[2:0] of RAM byte 0x20+(b>>3). Bit address b from 0x80 upward selects bit b[2:0] of register byte b&0xF8.
- R7: Bit set, clear and complement change only the addressed bit. They respond two cycles after acceptance, with rsp_data holding the new byte and rsp_bit holding the bit's previous value.
- R8: A bit test responds one cycle after acceptance, with rsp_bit holding the bit and rsp_data holding the containing byte. It writes nothing.
- R9: sp_out is 0x07 after reset. A push increments the pointer first and then writes req_wdata at the new pointer. It responds after one cycle.
- R10: A pop returns the byte at the pointer and then decrements the pointer. It responds after one cycle, so pushes and pops behave last-in first-out.
- R11: Direct byte and register operations respond one cycle after acceptance and indirect byte operations two cycles after. ready is high only in IDLE, and a request presented while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 2 | Active register bank (RS1:RS0) |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code |
| req_ind | input | 1 | 1 = indirect byte access |
| req_addr | input | 8 | Byte address, register number, Ri select or bit address |
| req_wdata | input | 8 | Write or push data |
| ready | output | 1 | Unit idle and accepting |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | 8 | Read, written or popped byte |
| rsp_bit | output | 1 | Bit value before the operation (bit operations) |
| sp_out | output | 8 | Stack pointer |
| sfr_addr | output | 8 | Register port address |
| sfr_re | output | 1 | Register port read strobe |
| sfr_we | output | 1 | Register port write strobe |
| sfr_wdata | output | 8 | Register port write data |
| sfr_rdata | input | 8 | Register port read data, same cycle |

## Verification
Several behaviours are checked every cycle by assertions. These are the stack pointer's reset value and its single-step moves on push and pop, and the fixed latencies of direct and read-modify-write requests. They also cover the rule that a response is always followed by ready, and the rule that the register port is never strobed while the stack or pointer fetch states are active or in the same cycle as a RAM write. Where each address actually lands can only be shown by the bench's request sequences: the direct and indirect split of the upper half, the bank arithmetic, the bit-to-byte mapping, LIFO order, and ignoring a request while busy. The bench writes through one path and reads back through another.

// File: rtl/iram_pkg.sv
package iram_pkg;

    typedef enum logic [3:0] {
        OP_BYTE_RD = 4'd0,
        OP_BYTE_WR = 4'd1,
        OP_REG_RD  = 4'd2,
        OP_REG_WR  = 4'd3,
        OP_BIT_RD  = 4'd4,
        OP_BIT_SET = 4'd5,
        OP_BIT_CLR = 4'd6,
        OP_BIT_CPL = 4'd7,
        OP_PUSH    = 4'd8,
        OP_POP     = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_FETCH,
        S_BYTE_XFER,
        S_BIT_READ,
        S_BIT_WRITE,
        S_STACK
    } state_e;

    function automatic logic op_is_bit(input op_e op);
        return (op == OP_BIT_RD) || (op == OP_BIT_SET) ||
               (op == OP_BIT_CLR) || (op == OP_BIT_CPL);
    endfunction

    function automatic logic op_is_byte_write(input op_e op);
        return (op == OP_BYTE_WR) || (op == OP_REG_WR);
    endfunction

endpackage

// File: rtl/iram_addr_map.sv
module iram_addr_map
    import iram_pkg::*;
#(
    parameter int AW = 8,
    parameter int BANK_W = 2,
    parameter int RPB = 8,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  op_e               op,
    input  logic              ind,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] bank,
    input  logic [AW-1:0]     ptr,
    input  logic [AW-1:0]     sp,
    output logic [AW-1:0]     ptr_addr,
    output logic [AW-1:0]     tgt_addr,
    output logic              tgt_sfr,
    output logic [2:0]        bit_pos
);
    localparam int RSH = $clog2(RPB);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] BYTE_MASK = ~AW'(7);
    localparam logic [AW-1:0] REG_MASK = AW'(RPB - 1);

    logic [AW-1:0] bank_base;
    logic [AW-1:0] reg_addr;

    assign bank_base = AW'(bank) << RSH;
    assign ptr_addr  = bank_base | AW'(addr[0]);
    assign reg_addr  = bank_base | (addr & REG_MASK);
    assign bit_pos   = addr[2:0];

    always_comb begin
        tgt_addr = addr;
        tgt_sfr  = 1'b0;
        case (op)
            OP_REG_RD, OP_REG_WR: tgt_addr = reg_addr;
            OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL: begin
                if (addr[AW-1]) begin
                    tgt_addr = addr & BYTE_MASK;
                    tgt_sfr  = 1'b1;
                end else begin
                    tgt_addr = BIT_BASE + (addr >> 3);
                end
            end
            OP_PUSH: tgt_addr = sp + ONE;
            OP_POP:  tgt_addr = sp;
            default: begin
                if (ind) tgt_addr = ptr;
                else     tgt_sfr  = addr[AW-1];
            end
        endcase
    end
endmodule

// File: rtl/iram_bit_alu.sv
module iram_bit_alu
    import iram_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] byte_in,
    input  logic [2:0]    pos,
    output logic [DW-1:0] byte_out,
    output logic          bit_old
);
    logic [DW-1:0] mask;

    assign mask    = DW'(1) << pos;
    assign bit_old = byte_in[pos];

    always_comb begin
        case (op)
            OP_BIT_SET: byte_out = byte_in | mask;
            OP_BIT_CLR: byte_out = byte_in & ~mask;
            OP_BIT_CPL: byte_out = byte_in ^ mask;
            default:    byte_out = byte_in;
        endcase
    end
endmodule

// File: rtl/iram_store.sv
module iram_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(g))) mem[g] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/iram_addr_unit.sv
module iram_addr_unit
    import iram_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int NBANK = 4,
    parameter int RPB = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07,
    parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(NBANK)-1:0] bank_sel,
    input  logic                     req_valid,
    input  logic [3:0]               req_op,
    input  logic                     req_ind,
    input  logic [AW-1:0]            req_addr,
    input  logic [DW-1:0]            req_wdata,
    output logic                     ready,
    output logic                     rsp_valid,
    output logic [DW-1:0]            rsp_data,
    output logic                     rsp_bit,
    output logic [AW-1:0]            sp_out,
    output logic [AW-1:0]            sfr_addr,
    output logic                     sfr_re,
    output logic                     sfr_we,
    output logic [DW-1:0]            sfr_wdata,
    input  logic [DW-1:0]            sfr_rdata
);
    localparam int BANK_W = $clog2(NBANK);
    localparam logic [AW-1:0] ONE = AW'(1);

    state_e state, state_nx;
    op_e    op_q, op_in;
    logic              ind_q;
    logic [AW-1:0]     addr_q, ptr_q, sp_q;
    logic [DW-1:0]     wdata_q, byte_q;
    logic [BANK_W-1:0] bank_q;

    logic [AW-1:0] ptr_addr, tgt_addr, ram_raddr;
    logic          tgt_sfr;
    logic [2:0]    bit_pos;
    logic [DW-1:0] ram_rdata, rd_byte, alu_in, alu_out, ram_wdata;
    logic          alu_old, ram_we, is_write;

    assign op_in = op_e'(req_op);

    iram_addr_map #(.AW(AW), .BANK_W(BANK_W), .RPB(RPB), .BIT_BASE(BIT_BASE)) u_map (
        .op(op_q), .ind(ind_q), .addr(addr_q), .bank(bank_q), .ptr(ptr_q), .sp(sp_q),
        .ptr_addr(ptr_addr), .tgt_addr(tgt_addr), .tgt_sfr(tgt_sfr), .bit_pos(bit_pos)
    );

    iram_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .we(ram_we), .waddr(tgt_addr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    iram_bit_alu #(.DW(DW)) u_alu (
        .op(op_q), .byte_in(alu_in), .pos(bit_pos), .byte_out(alu_out), .bit_old(alu_old)
    );

    assign ram_raddr = (state == S_PTR_FETCH) ? ptr_addr : tgt_addr;
    assign rd_byte   = tgt_sfr ? sfr_rdata : ram_rdata;
    assign alu_in    = (state == S_BIT_WRITE) ? byte_q : rd_byte;
    assign is_write  = op_is_byte_write(op_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    case (op_in)
                        OP_BYTE_RD, OP_BYTE_WR:
                            state_nx = req_ind ? S_PTR_FETCH : S_BYTE_XFER;
                        OP_REG_RD, OP_REG_WR:
                            state_nx = S_BYTE_XFER;
                        OP_BIT_RD, OP_BIT_SET, OP_BIT_CLR, OP_BIT_CPL:
                            state_nx = S_BIT_READ;
                        OP_PUSH, OP_POP:
                            state_nx = S_STACK;
                        default:
                            state_nx = S_IDLE;
                    endcase
                end
            end
            S_PTR_FETCH: state_nx = S_BYTE_XFER;
            S_BYTE_XFER: state_nx = S_IDLE;
            S_BIT_READ:  state_nx = (op_q == OP_BIT_RD) ? S_IDLE : S_BIT_WRITE;
            S_BIT_WRITE: state_nx = S_IDLE;
            S_STACK:     state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rsp_bit   = 1'b0;
        sfr_re    = 1'b0;
        sfr_we    = 1'b0;
        ram_we    = 1'b0;
        ram_wdata = wdata_q;
        unique case (state)
            S_IDLE: ready = 1'b1;
            S_PTR_FETCH: ;
            S_BYTE_XFER: begin
                rsp_valid = 1'b1;
                rsp_data  = is_write ? wdata_q : rd_byte;
                sfr_re    = tgt_sfr && !is_write;
                sfr_we    = tgt_sfr && is_write;
                ram_we    = !tgt_sfr && is_write;
            end
            S_BIT_READ: begin
                sfr_re = tgt_sfr;
                if (op_q == OP_BIT_RD) begin
                    rsp_valid = 1'b1;
                    rsp_data  = rd_byte;
                    rsp_bit   = alu_old;
                end
            end
            S_BIT_WRITE: begin
                rsp_valid = 1'b1;
                rsp_data  = alu_out;
                rsp_bit   = alu_old;
                ram_wdata = alu_out;
                sfr_we    = tgt_sfr;
                ram_we    = !tgt_sfr;
            end
            S_STACK: begin
                rsp_valid = 1'b1;
                rsp_data  = (op_q == OP_PUSH) ? wdata_q : ram_rdata;
                ram_we    = (op_q == OP_PUSH);
            end
            default: ;
        endcase
    end

    assign sfr_addr  = tgt_addr;
    assign sfr_wdata = ram_wdata;
    assign sp_out    = sp_q;

    // request capture and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_BYTE_RD;
            ind_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            bank_q  <= '0;
            ptr_q   <= '0;
            byte_q  <= '0;
            sp_q    <= SP_RESET;
        end else begin
            if (state == S_IDLE && req_valid) begin
                op_q    <= op_in;
                ind_q   <= req_ind;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                bank_q  <= bank_sel;
            end
            if (state == S_PTR_FETCH) ptr_q <= AW'(ram_rdata);
            if (state == S_BIT_READ)  byte_q <= rd_byte;
            if (state == S_STACK) begin
                if (op_q == OP_PUSH) sp_q <= sp_q + ONE;
                else                 sp_q <= sp_q - ONE;
            end
        end
    end
endmodule

// File: rtl/iram_addr_unit_chk.sv
module iram_addr_unit_chk
    import iram_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] SP_RESET = 8'h07
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          req_valid,
    input logic [3:0]    req_op,
    input logic          req_ind,
    input logic          rsp_valid,
    input logic [AW-1:0] sp_out,
    input logic          sfr_re,
    input logic          sfr_we,
    input logic          ram_we,
    input state_e        state,
    input op_e           op_q
);
    a_r9_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp_out == SP_RESET);

    a_r9_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STACK && op_q == OP_PUSH) |=> sp_out == $past(sp_out) + AW'(1));

    a_r10_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STACK && op_q == OP_POP) |=> sp_out == $past(sp_out) - AW'(1));

    a_r7_rmw_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && (req_op == 4'd5 || req_op == 4'd6 || req_op == 4'd7))
        |=> !rsp_valid ##1 rsp_valid);

    a_r11_direct_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req_valid && !req_ind && (req_op == 4'd0 || req_op == 4'd1)) |=> rsp_valid);

    a_r11_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> ready);

    a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && ram_we) && !(sfr_we && sfr_re));

    a_r3_no_port_in_stack_or_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STACK || state == S_PTR_FETCH) |-> !sfr_re && !sfr_we);
endmodule

bind iram_addr_unit iram_addr_unit_chk #(.AW(AW), .SP_RESET(SP_RESET)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .req_valid(req_valid), .req_op(req_op),
    .req_ind(req_ind), .rsp_valid(rsp_valid), .sp_out(sp_out), .sfr_re(sfr_re),
    .sfr_we(sfr_we), .ram_we(ram_we), .state(state), .op_q(op_q)
);

// File: tb/iram_addr_unit_tb_top.sv
`timescale 1ns/1ps
module iram_addr_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       req_valid = 1'b0;
    logic [3:0] req_op = '0;
    logic       req_ind = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       ready, rsp_valid, rsp_bit, sfr_re, sfr_we;
    logic [7:0] rsp_data, sp_out, sfr_addr, sfr_wdata, sfr_rdata;

    int n_chk = 0;
    int n_err = 0;
    int sfr_cnt = 0;
    logic [7:0] sfr_mem [128];

    always #2 clk = ~clk;

    iram_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .req_valid(req_valid),
        .req_op(req_op), .req_ind(req_ind), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_bit(rsp_bit),
        .sp_out(sp_out), .sfr_addr(sfr_addr), .sfr_re(sfr_re), .sfr_we(sfr_we),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // register-file model behind the port
    assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
    always @(posedge clk) begin
        if (sfr_we) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;
        if (sfr_re || sfr_we) sfr_cnt <= sfr_cnt + 1;
    end

    // {bank2, op4, ind1, addr8, wdata8, exp_data8, exp_bit1, exp_lat3}
    localparam int NV = 31;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 4'd1, 1'b0, 8'h30, 8'h5A, 8'h5A, 1'b0, 3'd1},
        {2'd0, 4'd0, 1'b0, 8'h30, 8'h00, 8'h5A, 1'b0, 3'd1},
        {2'd0, 4'd3, 1'b0, 8'h00, 8'h30, 8'h30, 1'b0, 3'd1},
        {2'd0, 4'd0, 1'b1, 8'h00, 8'h00, 8'h5A, 1'b0, 3'd2},
        {2'd2, 4'd3, 1'b0, 8'h01, 8'h90, 8'h90, 1'b0, 3'd1},
        {2'd2, 4'd1, 1'b1, 8'h01, 8'hC3, 8'hC3, 1'b0, 3'd2},
        {2'd0, 4'd0, 1'b0, 8'h11, 8'h00, 8'h90, 1'b0, 3'd1},
        {2'd0, 4'd1, 1'b0, 8'h90, 8'h77, 8'h77, 1'b0, 3'd1},
        {2'd0, 4'd0, 1'b0, 8'h90, 8'h00, 8'h77, 1'b0, 3'd1},
        {2'd2, 4'd0, 1'b1, 8'h01, 8'h00, 8'hC3, 1'b0, 3'd2},
        {2'd3, 4'd3, 1'b0, 8'h07, 8'hEE, 8'hEE, 1'b0, 3'd1},
        {2'd0, 4'd0, 1'b0, 8'h1F, 8'h00, 8'hEE, 1'b0, 3'd1},
        {2'd0, 4'd1, 1'b0, 8'h25, 8'h00, 8'h00, 1'b0, 3'd1},
        {2'd0, 4'd5, 1'b0, 8'h2B, 8'h00, 8'h08, 1'b0, 3'd2},
        {2'd0, 4'd4, 1'b0, 8'h2B, 8'h00, 8'h08, 1'b1, 3'd1},
        {2'd0, 4'd7, 1'b0, 8'h2F, 8'h00, 8'h88, 1'b0, 3'd2},
        {2'd0, 4'd6, 1'b0, 8'h2B, 8'h00, 8'h80, 1'b1, 3'd2},
        {2'd0, 4'd0, 1'b0, 8'h25, 8'h00, 8'h80, 1'b0, 3'd1},
        {2'd0, 4'd1, 1'b0, 8'h88, 8'h0F, 8'h0F, 1'b0, 3'd1},
        {2'd0, 4'd5, 1'b0, 8'h8E, 8'h00, 8'h4F, 1'b0, 3'd2},
        {2'd0, 4'd4, 1'b0, 8'h8A, 8'h00, 8'h4F, 1'b1, 3'd1},
        {2'd0, 4'd0, 1'b0, 8'h88, 8'h00, 8'h4F, 1'b0, 3'd1},
        {2'd0, 4'd8, 1'b0, 8'h00, 8'hA1, 8'hA1, 1'b0, 3'd1},
        {2'd0, 4'd8, 1'b0, 8'h00, 8'hB2, 8'hB2, 1'b0, 3'd1},
        {2'd0, 4'd0, 1'b0, 8'h09, 8'h00, 8'hB2, 1'b0, 3'd1},
        {2'd0, 4'd9, 1'b0, 8'h00, 8'h00, 8'hB2, 1'b0, 3'd1},
        {2'd0, 4'd9, 1'b0, 8'h00, 8'h00, 8'hA1, 1'b0, 3'd1},
        {2'd0, 4'd1, 1'b0, 8'h2F, 8'h00, 8'h00, 1'b0, 3'd1},
        {2'd0, 4'd5, 1'b0, 8'h7F, 8'h00, 8'h80, 1'b0, 3'd2},
        {2'd0, 4'd1, 1'b0, 8'h20, 8'hFE, 8'hFE, 1'b0, 3'd1},
        {2'd0, 4'd7, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b0, 3'd2}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic run_req(input logic [1:0] bk, input logic [3:0] op, input logic ind,
                           input logic [7:0] addr, input logic [7:0] wd,
                           output logic [7:0] data, output logic bitv, output int lat);
        @(negedge clk);
        while (!ready) @(negedge clk);
        bank_sel = bk; req_op = op; req_ind = ind; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        data = rsp_data;
        bitv = rsp_bit;
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic ind, input logic [7:0] a);
        case (op)
            4'd0, 4'd1: return ind ? "R5" : (a[7] ? "R2" : "R1");
            4'd2, 4'd3: return "R4";
            4'd4:       return "R8";
            4'd5, 4'd6, 4'd7: return "R7";
            4'd8:       return "R9";
            default:    return "R10";
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic b;
        int lat;
        int cnt0;
        repeat (3) @(negedge clk);
        // reset state (R9, R11)
        check("R11 ready in reset", {7'd0, ready}, 8'd1);
        check("R11 no rsp in reset", {7'd0, rsp_valid}, 8'd0);
        check("R9 sp reset", sp_out, 8'h07);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 sp after reset", sp_out, 8'h07);

        for (int i = 0; i < NV; i++) begin
            logic [34:0] v;
            string t;
            v = VEC[i];
            t = tag_of(v[32:29], v[28], v[27:20]);
            run_req(v[34:33], v[32:29], v[28], v[27:20], v[19:12], d, b, lat);
            check($sformatf("%s data row %0d", (v[32:29] inside {4'd4, 4'd5, 4'd6, 4'd7}) ? "R6" : t, i), d, v[11:4]);
            if (v[32:29] inside {4'd4, 4'd5, 4'd6, 4'd7})
                check($sformatf("%s bit row %0d", t, i), {7'd0, b}, {7'd0, v[3]});
            check($sformatf("R11 latency row %0d", i), 8'(lat), {5'd0, v[2:0]});
        end
        check("R10 sp back to reset after LIFO", sp_out, 8'h07);

        // R3: indirect upper page never touches the register port
        cnt0 = sfr_cnt;
        run_req(2'd2, 4'd1, 1'b1, 8'h01, 8'h3C, d, b, lat);
        @(negedge clk);
        check("R3 no port strobe", 8'(sfr_cnt - cnt0), 8'd0);
        check("R3 port byte kept", sfr_mem[7'h10], 8'h77);
        run_req(2'd2, 4'd0, 1'b1, 8'h01, 8'h00, d, b, lat);
        check("R3 upper page read", d, 8'h3C);
        run_req(2'd0, 4'd0, 1'b0, 8'h90, 8'h00, d, b, lat);
        check("R2 direct still register", d, 8'h77);

        // R11: a request while busy is ignored
        run_req(2'd0, 4'd1, 1'b0, 8'h32, 8'h11, d, b, lat);
        @(negedge clk);
        bank_sel = 2'd0; req_op = 4'd0; req_ind = 1'b1; req_addr = 8'h00; req_valid = 1'b1;
        @(negedge clk);
        check("R11 busy not ready", {7'd0, ready}, 8'd0);
        req_op = 4'd1; req_ind = 1'b0; req_addr = 8'h32; req_wdata = 8'hFF;
        @(negedge clk);
        check("R5 indirect via R0", rsp_data, 8'h5A);
        req_valid = 1'b0;
        run_req(2'd0, 4'd0, 1'b0, 8'h32, 8'h00, d, b, lat);
        check("R11 busy request ignored", d, 8'h11);

        finish_run();
    end
endmodule